// File: doc/BRIEF.md
# Mode-Aware General-Purpose Pin Port Controller

This block manages a port of general-purpose pins that share their pads with the low lanes of an external data bus. It keeps three registers that software reads and writes over a simple 16-bit register bus. The direction register sets each pin as input or output. The function-select register lets software choose, pin by pin, between the data bus and general I/O. The output data latch holds the values the port drives. A two-bit chip operating-mode input decides which pins the external bus owns. In some modes it overrides the function-select register completely.

For each pin the block forms the pad output enable and the pad output value. When the bus owns a pin, the bus controller's drive signals go straight through to that pin and the pad value returns on the bus sample lines. When general I/O owns a pin, the direction bit and the data latch drive it. Pad inputs pass through a synchronizer before they reach the port data read path. The registers respond to each reset or low-power source in a different way. The asynchronous power-on reset and hardware standby clear them. A watchdog-initiated power-on reset, software standby and sleep leave them as they are.

Top module: `pin_port_ctrl`

## Requirements
- R1: While rst_ni is low, and after it, the direction, function-select and data latch registers all read 0 and every pad_oe_o bit is 0. rst_ni acts asynchronously.
- R2: The register address selects a register: 0 is direction, 1 is function-select and 2 is port data, and address 3 reads 0. A write with reg_we_i high takes effect at the next clock edge. Reads of addresses 0 and 1 always return the stored value, whatever the operating mode.
- R3: mode_i=0 (single-chip): every pin is general I/O and the function-select register has no effect, so pin_is_bus_o is 0.
- R4: mode_i=1 (expanded, internal ROM on): each pin follows its function-select bit. 1 gives the pin to the data bus and 0 gives it to general I/O.
- R5: mode_i=2 (expanded, no internal ROM, 8-bit bus): pins 0 to 7 belong to the data bus and pins 8 to 15 are general I/O, whatever the function-select register holds.
- R6: mode_i=3 (expanded, no internal ROM, 16-bit bus): every pin belongs to the data bus, whatever the function-select register holds.
- R7: On a general I/O pin, pad_oe_o equals the direction bit (1 is output) and pad_out_o equals the data latch bit. On a bus pin the direction bit has no effect.
- R8: On a bus pin, pad_oe_o equals bus_oe_i, pad_out_o equals the bus_dout_i bit, and bus_din_o carries pad_in_i. bus_din_o is 0 on general I/O pins.
- R9: A read of address 2 returns the data latch bit for a general I/O pin whose direction is output. For every other pin it returns pad_in_i delayed by two clock edges.
- R10: A clock edge with hw_stby_i high clears all three registers.
- R11: wdt_por_i, sw_stby_i and sleep_i never change the registers. A register write is ignored while any of wdt_por_i, sw_stby_i, sleep_i or hw_stby_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| wdt_por_i | input | 1 | Watchdog-initiated power-on reset active |
| hw_stby_i | input | 1 | Hardware standby active |
| sw_stby_i | input | 1 | Software standby active |
| sleep_i | input | 1 | Sleep active |
| mode_i | input | 2 | Chip operating mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| bus_oe_i | input | 1 | External bus drive enable |
| bus_dout_i | input | 16 | External bus write data |
| bus_din_o | output | 16 | External bus sampled data |
| pad_in_i | input | 16 | Pad input values |
| pad_out_o | output | 16 | Pad output values |
| pad_oe_o | output | 16 | Pad output enables |
| pin_is_bus_o | output | 16 | Pin currently owned by the data bus |

## Verification
The bench builds the block with its default parameters: 16 pins, an 8-pin narrow bus split and two synchronizer stages. With these values each of the four operating modes gives a different ownership pattern on the same register contents, and the bench can observe them at the ports. The two-stage depth lets the bench check that a new pad value is absent after one edge and present after two. Holding the function-select and direction registers fixed while the mode changes shows at the ports whether a mode overrides a register or leaves it in effect.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_EXP_ROM  = 2'd1,
    MODE_NOROM_8  = 2'd2,
    MODE_NOROM_16 = 2'd3
  } op_mode_e;

  typedef enum logic [1:0] {
    ADDR_DIR  = 2'd0,
    ADDR_FUNC = 2'd1,
    ADDR_DATA = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pin_port_regs.sv
module pin_port_regs #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         we_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] func_o,
  output logic [W-1:0] data_o
);
  import pin_port_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '0;
      func_o <= '0;
      data_o <= '0;
    end else if (clear_i) begin
      dir_o  <= '0;
      func_o <= '0;
      data_o <= '0;
    end else if (we_i) begin
      case (reg_addr_e'(addr_i))
        ADDR_DIR:  dir_o  <= wdata_i;
        ADDR_FUNC: func_o <= wdata_i;
        ADDR_DATA: data_o <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pin_port_owner.sv
module pin_port_owner #(
  parameter int W      = 16,
  parameter int NARROW = 8
) (
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] func_i,
  output logic [W-1:0] bus_own_o
);
  import pin_port_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_pin
    localparam logic IN_NARROW = (i < NARROW);
    always_comb begin
      case (op_mode_e'(mode_i))
        MODE_SINGLE:   bus_own_o[i] = 1'b0;
        MODE_EXP_ROM:  bus_own_o[i] = func_i[i];
        MODE_NOROM_8:  bus_own_o[i] = IN_NARROW;
        MODE_NOROM_16: bus_own_o[i] = 1'b1;
        default:       bus_own_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pin_port_sync.sv
module pin_port_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pin_port_slice.sv
module pin_port_slice (
  input  logic own_bus_i,
  input  logic dir_i,
  input  logic data_i,
  input  logic bus_oe_i,
  input  logic bus_dout_i,
  input  logic pad_in_i,
  input  logic pad_sync_i,
  output logic pad_oe_o,
  output logic pad_out_o,
  output logic bus_din_o,
  output logic rd_bit_o
);
  logic gpio_drive;

  assign gpio_drive = !own_bus_i && dir_i;
  assign pad_oe_o   = own_bus_i ? bus_oe_i   : dir_i;
  assign pad_out_o  = own_bus_i ? bus_dout_i : data_i;
  assign bus_din_o  = own_bus_i && pad_in_i;
  // driven GPIO pins read back the latch, all others the synchronized pad
  assign rd_bit_o   = gpio_drive ? data_i : pad_sync_i;
endmodule

// File: rtl/pin_port_ctrl.sv
module pin_port_ctrl #(
  parameter int NUM_PINS    = 16,
  parameter int NARROW_PINS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wdt_por_i,
  input  logic                hw_stby_i,
  input  logic                sw_stby_i,
  input  logic                sleep_i,
  input  logic [1:0]          mode_i,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [NUM_PINS-1:0] reg_wdata_i,
  output logic [NUM_PINS-1:0] reg_rdata_o,
  input  logic                bus_oe_i,
  input  logic [NUM_PINS-1:0] bus_dout_i,
  output logic [NUM_PINS-1:0] bus_din_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pin_is_bus_o
);
  import pin_port_pkg::*;

  localparam int W = NUM_PINS;

  logic         wr_block, wr_en;
  logic [W-1:0] dir_q, func_q, data_q;
  logic [W-1:0] bus_own, pad_sync, port_rd;

  assign wr_block = wdt_por_i | hw_stby_i | sw_stby_i | sleep_i;
  assign wr_en    = reg_we_i & ~wr_block;

  pin_port_regs #(.W(W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (hw_stby_i),
    .we_i    (wr_en),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .dir_o   (dir_q),
    .func_o  (func_q),
    .data_o  (data_q)
  );

  pin_port_owner #(.W(W), .NARROW(NARROW_PINS)) i_owner (
    .mode_i    (mode_i),
    .func_i    (func_q),
    .bus_own_o (bus_own)
  );

  pin_port_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pad_sync)
  );

  for (genvar i = 0; i < W; i++) begin : g_slice
    pin_port_slice i_slice (
      .own_bus_i  (bus_own[i]),
      .dir_i      (dir_q[i]),
      .data_i     (data_q[i]),
      .bus_oe_i   (bus_oe_i),
      .bus_dout_i (bus_dout_i[i]),
      .pad_in_i   (pad_in_i[i]),
      .pad_sync_i (pad_sync[i]),
      .pad_oe_o   (pad_oe_o[i]),
      .pad_out_o  (pad_out_o[i]),
      .bus_din_o  (bus_din_o[i]),
      .rd_bit_o   (port_rd[i])
    );
  end

  always_comb begin
    case (reg_addr_e'(reg_addr_i))
      ADDR_DIR:  reg_rdata_o = dir_q;
      ADDR_FUNC: reg_rdata_o = func_q;
      ADDR_DATA: reg_rdata_o = port_rd;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign pin_is_bus_o = bus_own;
endmodule

// File: rtl/pin_port_ctrl_chk.sv
module pin_port_ctrl_chk #(
  parameter int W      = 16,
  parameter int NARROW = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wdt_por_i,
  input logic         hw_stby_i,
  input logic         sw_stby_i,
  input logic         sleep_i,
  input logic [1:0]   mode_i,
  input logic [1:0]   reg_addr_i,
  input logic [W-1:0] reg_rdata_o,
  input logic         bus_oe_i,
  input logic [W-1:0] bus_dout_i,
  input logic [W-1:0] bus_din_o,
  input logic [W-1:0] pad_out_o,
  input logic [W-1:0] pad_oe_o,
  input logic [W-1:0] pin_is_bus_o
);
  localparam logic [W-1:0] NARROW_MASK = W'((64'd1 << NARROW) - 64'd1);

  logic quiet;
  assign quiet = (wdt_por_i | sw_stby_i | sleep_i) & ~hw_stby_i;

  AST_SINGLE_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd0 |-> pin_is_bus_o == '0) else $error("single-chip bus pin"); // R3

  AST_NARROW_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd2 |-> pin_is_bus_o == NARROW_MASK) else $error("narrow split"); // R5

  AST_WIDE_ALL_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd3 |-> pin_is_bus_o == '1) else $error("wide mode"); // R6

  AST_BUS_OE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & pin_is_bus_o) == (bus_oe_i ? pin_is_bus_o : '0)) else $error("bus oe"); // R8

  AST_BUS_DOUT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o ^ bus_dout_i) & pin_is_bus_o) == '0) else $error("bus dout"); // R8

  AST_BUS_DIN_GPIO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_din_o & ~pin_is_bus_o) == '0) else $error("bus din leak"); // R8

  AST_STBY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_i |=> (reg_addr_i[1] || reg_rdata_o == '0)) else $error("standby clear"); // R10

  AST_LOWPWR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && !reg_addr_i[1]) |=>
      (reg_addr_i != $past(reg_addr_i) || $stable(reg_rdata_o))) else $error("low-power hold"); // R11
endmodule

bind pin_port_ctrl pin_port_ctrl_chk #(.W(NUM_PINS), .NARROW(NARROW_PINS)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wdt_por_i    (wdt_por_i),
  .hw_stby_i    (hw_stby_i),
  .sw_stby_i    (sw_stby_i),
  .sleep_i      (sleep_i),
  .mode_i       (mode_i),
  .reg_addr_i   (reg_addr_i),
  .reg_rdata_o  (reg_rdata_o),
  .bus_oe_i     (bus_oe_i),
  .bus_dout_i   (bus_dout_i),
  .bus_din_o    (bus_din_o),
  .pad_out_o    (pad_out_o),
  .pad_oe_o     (pad_oe_o),
  .pin_is_bus_o (pin_is_bus_o)
);

// File: tb/test_pin_port_ctrl.sv
`timescale 1ns/1ps
module test_pin_port_ctrl;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wdt_por_i = 0, hw_stby_i = 0, sw_stby_i = 0, sleep_i = 0;
  logic [1:0]   mode_i = 2'd0;
  logic         reg_we_i = 0;
  logic [1:0]   reg_addr_i = 2'd0;
  logic [W-1:0] reg_wdata_i = '0;
  logic [W-1:0] reg_rdata_o;
  logic         bus_oe_i = 0;
  logic [W-1:0] bus_dout_i = '0;
  logic [W-1:0] bus_din_o;
  logic [W-1:0] pad_in_i = '0;
  logic [W-1:0] pad_out_o, pad_oe_o, pin_is_bus_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_port_ctrl i_pin_port_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .wdt_por_i(wdt_por_i), .hw_stby_i(hw_stby_i),
    .sw_stby_i(sw_stby_i), .sleep_i(sleep_i), .mode_i(mode_i), .reg_we_i(reg_we_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .bus_oe_i(bus_oe_i), .bus_dout_i(bus_dout_i), .bus_din_o(bus_din_o),
    .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
    .pin_is_bus_o(pin_is_bus_o)
  );

  // sel: 0 rdata, 1 pad_oe, 2 pad_out, 3 bus_din, 4 pin_is_bus
  typedef struct {
    int           sel;
    logic [W-1:0] exp;
    string        req;
  } item_t;
  item_t sb_q[$];

  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [W-1:0] act;
      it = sb_q.pop_front();
      case (it.sel)
        0: act = reg_rdata_o;
        1: act = pad_oe_o;
        2: act = pad_out_o;
        3: act = bus_din_o;
        default: act = pin_is_bus_o;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_val(int sel, logic [W-1:0] exp, string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    tick();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [W-1:0] exp, string req);
    reg_addr_i = a;
    expect_val(0, exp, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rd(2'd0, 16'h0000, "R1");
    rd(2'd1, 16'h0000, "R1");
    expect_val(1, 16'h0000, "R1");
    rst_ni = 1'b1;
    tick();
    rd(2'd2, 16'h0000, "R1");

    wr(2'd0, 16'hA5C3);
    wr(2'd1, 16'h0F0F);
    wr(2'd2, 16'h1234);
    rd(2'd0, 16'hA5C3, "R2");
    rd(2'd1, 16'h0F0F, "R2");
    rd(2'd3, 16'h0000, "R2");

    mode_i = 2'd0;
    expect_val(4, 16'h0000, "R3");
    expect_val(1, 16'hA5C3, "R7");
    expect_val(2, 16'h1234, "R7");

    mode_i = 2'd1; bus_oe_i = 1'b1; bus_dout_i = 16'hFFFF; pad_in_i = 16'h5555;
    expect_val(4, 16'h0F0F, "R4");
    expect_val(1, 16'hAFCF, "R8");
    expect_val(2, 16'h1F3F, "R8");
    expect_val(3, 16'h0505, "R8");
    rd(2'd1, 16'h0F0F, "R2");

    mode_i = 2'd2; bus_oe_i = 1'b0;
    expect_val(4, 16'h00FF, "R5");
    expect_val(1, 16'hA500, "R7");

    mode_i = 2'd3;
    expect_val(4, 16'hFFFF, "R6");
    expect_val(2, 16'hFFFF, "R6");
    rd(2'd0, 16'hA5C3, "R2");

    mode_i = 2'd0;
    tick(); tick();
    rd(2'd2, 16'h5014, "R9");
    pad_in_i = 16'hAAAA;
    tick();
    rd(2'd2, 16'h5014, "R9");
    tick();
    rd(2'd2, 16'h0A28, "R9");
    mode_i = 2'd1;
    rd(2'd2, 16'h0A2A, "R9");
    mode_i = 2'd0;

    sleep_i = 1'b1;
    wr(2'd0, 16'hFFFF);
    sleep_i = 1'b0;
    rd(2'd0, 16'hA5C3, "R11");
    sw_stby_i = 1'b1;
    wr(2'd1, 16'hFFFF);
    tick();
    sw_stby_i = 1'b0;
    rd(2'd1, 16'h0F0F, "R11");
    wdt_por_i = 1'b1;
    wr(2'd2, 16'hBEEF);
    tick();
    wdt_por_i = 1'b0;
    expect_val(2, 16'h1234, "R11");
    rd(2'd0, 16'hA5C3, "R11");

    hw_stby_i = 1'b1;
    tick();
    hw_stby_i = 1'b0;
    rd(2'd0, 16'h0000, "R10");
    rd(2'd1, 16'h0000, "R10");
    expect_val(2, 16'h0000, "R10");

    wr(2'd0, 16'h00F0);
    rd(2'd0, 16'h00F0, "R2");
    #0.5 rst_ni = 1'b0;
    #0.5;
    rd(2'd0, 16'h0000, "R1");
    expect_val(1, 16'h0000, "R1");
    rst_ni = 1'b1;
    tick();

    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule